// File: doc/BRIEF.md
# SPI Master FIFO, Status and Interrupt Front End

This block sits between a register bus and the shift engine of an SPI master. Software writes outgoing words into a transmit queue and takes incoming words out of a receive queue, both through memory-mapped data registers. The engine drains the transmit queue and fills the receive queue through streaming ports. It also pulses a strobe when a transfer has finished. The serial protocol and the bit clock are handled elsewhere.

Eight status flags are built from the two fill levels, from two programmable watermarks, and from two sticky event bits: receive overflow and transfer complete. An interrupt-enable register uses the same bit positions as the status register. One level-sensitive interrupt line is raised whenever any enabled flag is set.

The engine transmit port is valid/ready. A word leaves the queue on a cycle where both are high, and valid stays high with stable data while ready is low. The engine receive port has valid only and applies no back-pressure. A word that arrives while the receive queue is full is dropped and is reported through the overflow flag. Register reads return data in the same cycle, and a read of the receive-data register removes the word it returns.

Top module: `spim_front`

## Requirements
- R1: After reset both queues are empty, the sticky bits, the enables and both watermarks are zero, the status register reads 0x03, the interrupt line is low and eng_tx_valid is low.
- R2: Each write to offset 0x04 appends one word to the transmit queue. eng_tx_valid is high while the queue holds a word, and eng_tx_data shows the oldest word. A word is removed on each cycle where eng_tx_valid and eng_tx_ready are both high, so words leave in the order they were written.
- R3: A write to offset 0x04 while the transmit queue holds DEPTH words is ignored: the words already in the queue and their order are unchanged.
- R4: An eng_rx_valid pulse appends eng_rx_data to the receive queue. A read of offset 0x00 returns the oldest word and removes it. A read of offset 0x00 while the queue is empty returns zero and changes no state.
- R5: If eng_rx_valid arrives while the receive queue is full (fullness is judged at the start of the cycle), the word is discarded, the queue contents are unchanged, and status bit 6 (overflow) becomes 1.
- R6: Status bits at offset 0x18: bit 0 is transmit empty; bit 1 is transmit level <= transmit watermark; bit 2 is transmit full; bit 3 is receive not empty; bit 4 is receive level > receive watermark; bit 5 is receive full. The watermark register at offset 0x14 holds the transmit watermark in bits 5:0 and the receive watermark in bits 21:16.
- R7: A one-cycle eng_done pulse sets status bit 7 (transfer complete), and the bit stays set until it is cleared.
- R8: Writing status with bit 6 or bit 7 at 1 clears that bit, and a 0 in that position leaves it as it is. Writing back a value that was read from status clears every sticky bit that was set in that value. If a set event and a clear happen in the same cycle, the bit ends up set.
- R9: The interrupt-enable register at offset 0x10 (bits 7:0) uses the status bit positions. irq is high exactly when (status AND enable) is non-zero.
- R10: Reads of offsets 0x10 and 0x14 return the written field values, and all other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe (pops receive data at 0x00) |
| reg_rdata | output | 32 | Register read data, valid in the same cycle |
| eng_tx_valid | output | 1 | Transmit queue holds a word |
| eng_tx_ready | input | 1 | Engine takes the offered word |
| eng_tx_data | output | DATA_W | Oldest transmit word |
| eng_rx_valid | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_done | input | 1 | Transfer-complete strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH = 8 and DATA_W = 16. With a queue that short, both queues can be filled to capacity with only a few words. This makes it cheap to reach the ignored write on a full transmit queue, the receive overflow that drops a word, and both watermark edges. The 6-bit watermark fields still cover every level of the smaller queues. They are set to values on each side of the fill level, so both the at-or-below edge and the strictly-above edge are exercised.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int OFS_RXD  = 'h00;
  localparam int OFS_TXD  = 'h04;
  localparam int OFS_IEN  = 'h10;
  localparam int OFS_THR  = 'h14;
  localparam int OFS_STAT = 'h18;

  localparam int ST_TXE   = 0;
  localparam int ST_TXREQ = 1;
  localparam int ST_TXF   = 2;
  localparam int ST_RXNE  = 3;
  localparam int ST_RXRDY = 4;
  localparam int ST_RXF   = 5;
  localparam int ST_OVF   = 6;
  localparam int ST_TC    = 7;
  localparam int NFLAG    = 8;

  localparam int THR_W    = 6;
  localparam int THR_RX_LSB = 16;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [LW-1:0]     level,
  output logic              empty,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0] wr_ptr, rd_ptr;

  assign level = wr_ptr - rd_ptr;
  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));
  assign head  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R4
endmodule

// File: rtl/spim_status.sv
module spim_status
  import spim_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH) + 1,
  localparam int CW = (LW > THR_W) ? LW : THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LW-1:0]    tx_level,
  input  logic [LW-1:0]    rx_level,
  input  logic [THR_W-1:0] tx_thr,
  input  logic [THR_W-1:0] rx_thr,
  input  logic             rx_drop,
  input  logic             xfer_done,
  input  logic             clr_wr,
  input  logic [NFLAG-1:0] clr_mask,
  input  logic [NFLAG-1:0] ien,
  output logic [NFLAG-1:0] status,
  output logic             irq
);
  logic ovf_q, tc_q;
  logic [CW-1:0] txl_x, rxl_x, txt_x, rxt_x;

  assign txl_x = CW'(tx_level);
  assign rxl_x = CW'(rx_level);
  assign txt_x = CW'(tx_thr);
  assign rxt_x = CW'(rx_thr);

  always_comb begin
    status           = '0;
    status[ST_TXE]   = (tx_level == '0);
    status[ST_TXREQ] = (txl_x <= txt_x);
    status[ST_TXF]   = (tx_level == LW'(DEPTH));
    status[ST_RXNE]  = (rx_level != '0);
    status[ST_RXRDY] = (rxl_x > rxt_x);
    status[ST_RXF]   = (rx_level == LW'(DEPTH));
    status[ST_OVF]   = ovf_q;
    status[ST_TC]    = tc_q;
  end

  assign irq = |(status & ien);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      tc_q  <= 1'b0;
    end else begin
      if (rx_drop)                          ovf_q <= 1'b1;
      else if (clr_wr && clr_mask[ST_OVF])  ovf_q <= 1'b0;
      if (xfer_done)                        tc_q  <= 1'b1;
      else if (clr_wr && clr_mask[ST_TC])   tc_q  <= 1'b0;
    end
  end

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> status[ST_OVF]); // R5
  AST_TC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_TC] && !(clr_wr && clr_mask[ST_TC])) |=> status[ST_TC]); // R7
  AST_TC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> status[ST_TC]); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq); // R9
endmodule

// File: rtl/spim_front.sv
module spim_front
  import spim_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 5,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  output logic              eng_tx_valid,
  input  logic              eng_tx_ready,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_rx_valid,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              eng_done,
  output logic              irq
);
  logic sel_rxd, sel_txd, sel_ien, sel_thr, sel_stat;
  logic tx_push, tx_pop, tx_empty, tx_full;
  logic rx_push, rx_pop, rx_empty, rx_full, rx_drop;
  logic [LW-1:0] tx_level, rx_level;
  logic [DATA_W-1:0] rx_head;
  logic [NFLAG-1:0] ien_q, status;
  logic [THR_W-1:0] tx_thr_q, rx_thr_q;

  assign sel_rxd  = (reg_addr == ADDR_W'(OFS_RXD));
  assign sel_txd  = (reg_addr == ADDR_W'(OFS_TXD));
  assign sel_ien  = (reg_addr == ADDR_W'(OFS_IEN));
  assign sel_thr  = (reg_addr == ADDR_W'(OFS_THR));
  assign sel_stat = (reg_addr == ADDR_W'(OFS_STAT));

  assign tx_push = reg_wr && sel_txd && !tx_full;
  assign tx_pop  = eng_tx_ready && !tx_empty;
  assign rx_push = eng_rx_valid && !rx_full;
  assign rx_drop = eng_rx_valid && rx_full;
  assign rx_pop  = reg_rd && sel_rxd && !rx_empty;

  assign eng_tx_valid = !tx_empty;

  spim_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .push_data(reg_wdata[DATA_W-1:0]),
    .pop(tx_pop), .head(eng_tx_data),
    .level(tx_level), .empty(tx_empty), .full(tx_full));

  spim_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .push_data(eng_rx_data),
    .pop(rx_pop), .head(rx_head),
    .level(rx_level), .empty(rx_empty), .full(rx_full));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q    <= '0;
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else if (reg_wr) begin
      if (sel_ien) ien_q <= reg_wdata[NFLAG-1:0];
      if (sel_thr) begin
        tx_thr_q <= reg_wdata[THR_W-1:0];
        rx_thr_q <= reg_wdata[THR_RX_LSB +: THR_W];
      end
    end
  end

  spim_status #(.DEPTH(DEPTH)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(tx_thr_q), .rx_thr(rx_thr_q),
    .rx_drop(rx_drop), .xfer_done(eng_done),
    .clr_wr(reg_wr && sel_stat), .clr_mask(reg_wdata[NFLAG-1:0]),
    .ien(ien_q), .status(status), .irq(irq));

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (sel_rxd && !rx_empty) reg_rdata = 32'(rx_head);
      else if (sel_ien)         reg_rdata = 32'(ien_q);
      else if (sel_thr)         reg_rdata = (32'(rx_thr_q) << THR_RX_LSB) | 32'(tx_thr_q);
      else if (sel_stat)        reg_rdata = 32'(status);
    end
  end

  AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel_rxd && rx_empty) |-> (reg_rdata == '0)); // R4
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_valid && !eng_tx_ready && !(reg_wr && sel_txd)) |=>
      (eng_tx_valid && $stable(eng_tx_data))); // R2
  AST_RX_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !(reg_rd && sel_rxd)) |=> rx_full); // R5
endmodule

// File: tb/spim_front_bench.sv
module spim_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DEP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic eng_tx_valid, eng_tx_ready = 1'b0;
  logic [DW-1:0] eng_tx_data;
  logic eng_rx_valid = 1'b0;
  logic [DW-1:0] eng_rx_data = '0;
  logic eng_done = 1'b0;
  logic irq;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spim_front #(.DATA_W(DW), .DEPTH(DEP), .ADDR_W(5)) u_spim_front (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready),
    .eng_tx_data(eng_tx_data), .eng_rx_valid(eng_rx_valid),
    .eng_rx_data(eng_rx_data), .eng_done(eng_done), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [DW-1:0] d);
    @(negedge clk);
    eng_rx_valid = 1'b1; eng_rx_data = d;
    @(posedge clk); #1 eng_rx_valid = 1'b0;
  endtask

  task automatic tx_take(output logic v, output logic [DW-1:0] d);
    @(negedge clk);
    eng_tx_ready = 1'b1;
    #1 v = eng_tx_valid; d = eng_tx_data;
    @(posedge clk); #1 eng_tx_ready = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1'b1;
    @(posedge clk); #1 eng_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] s;
    check("R1 irq", 32'(irq), 0);
    check("R1 tx_valid", 32'(eng_tx_valid), 0);
    rd(5'h18, s); check("R1 status", s, 32'h03);
    rd(5'h10, s); check("R1 ien", s, 0);
    rd(5'h14, s); check("R1 thr", s, 0);
  endtask

  task automatic t_tx_order();
    logic v; logic [DW-1:0] d; logic [31:0] s;
    wr(5'h04, 32'hA1); wr(5'h04, 32'hB2); wr(5'h04, 32'hC3);
    rd(5'h18, s); check("R6 tx level3 status", s, 32'h00);
    tx_take(v, d); check("R2 v0", 32'(v), 1); check("R2 w0", 32'(d), 32'hA1);
    tx_take(v, d); check("R2 w1", 32'(d), 32'hB2);
    tx_take(v, d); check("R2 w2", 32'(d), 32'hC3);
    #1 check("R2 drained", 32'(eng_tx_valid), 0);
  endtask

  task automatic t_tx_full();
    logic v; logic [DW-1:0] d; logic [31:0] s;
    for (int i = 0; i <= DEP; i++) wr(5'h04, 32'h100 + 32'(i));
    rd(5'h18, s); check("R6 tx full status", s, 32'h04);
    for (int i = 0; i < DEP; i++) begin
      tx_take(v, d); check("R3 drain order", 32'(d), 32'h100 + 32'(i));
    end
    #1 check("R3 extra write ignored", 32'(eng_tx_valid), 0);
  endtask

  task automatic t_rx();
    logic [31:0] s;
    rx_push(16'h1111); rx_push(16'h2222);
    rd(5'h18, s); check("R6 rx 2 status", s, 32'h1B);
    rd(5'h00, s); check("R4 rx w0", s, 32'h1111);
    rd(5'h00, s); check("R4 rx w1", s, 32'h2222);
    rd(5'h00, s); check("R4 empty read zero", s, 0);
    rd(5'h18, s); check("R4 empty read no change", s, 32'h03);
  endtask

  task automatic t_rx_ovf();
    logic [31:0] s;
    for (int i = 0; i <= DEP; i++) rx_push(16'h300 + 16'(i));
    rd(5'h18, s); check("R5 overflow status", s, 32'h7B);
    for (int i = 0; i < DEP; i++) begin
      rd(5'h00, s); check("R5 contents kept", s, 32'h300 + 32'(i));
    end
    rd(5'h00, s); check("R5 dropped word absent", s, 0);
    rd(5'h18, s); check("R8 ovf before clear", s, 32'h43);
    wr(5'h18, s);
    rd(5'h18, s); check("R8 write-back clears", s, 32'h03);
  endtask

  task automatic t_thresholds();
    logic v; logic [DW-1:0] d; logic [31:0] s;
    wr(5'h14, 32'hFFC3_FFC2);
    rd(5'h14, s); check("R10 thr readback", s, 32'h0003_0002);
    wr(5'h04, 1); wr(5'h04, 2);
    rd(5'h18, s); check("R6 tx at watermark", s, 32'h02);
    wr(5'h04, 3);
    rd(5'h18, s); check("R6 tx above watermark", s, 32'h00);
    for (int i = 0; i < 3; i++) tx_take(v, d);
    for (int i = 0; i < 3; i++) rx_push(16'(i));
    rd(5'h18, s); check("R6 rx at watermark", s, 32'h0B);
    rx_push(16'h9);
    rd(5'h18, s); check("R6 rx above watermark", s, 32'h1B);
    for (int i = 0; i < 4; i++) rd(5'h00, s);
    wr(5'h14, 0);
  endtask

  task automatic t_tc_w1c();
    logic [31:0] s;
    done_pulse();
    rd(5'h18, s); check("R7 tc set", s, 32'h83);
    repeat (3) @(posedge clk);
    rd(5'h18, s); check("R7 tc sticky", s, 32'h83);
    wr(5'h18, 32'h00);
    rd(5'h18, s); check("R8 zero write keeps", s, 32'h83);
    wr(5'h18, 32'h80);
    rd(5'h18, s); check("R8 w1c tc", s, 32'h03);
    @(negedge clk);
    eng_done = 1'b1; reg_addr = 5'h18; reg_wdata = 32'h80; reg_wr = 1'b1;
    @(posedge clk); #1 eng_done = 1'b0; reg_wr = 1'b0;
    rd(5'h18, s); check("R8 set wins", s, 32'h83);
    wr(5'h18, 32'hC0);
  endtask

  task automatic t_irq();
    logic [31:0] s;
    wr(5'h10, 32'hFFFF_FF80);
    rd(5'h10, s); check("R10 ien readback", s, 32'h80);
    #1 check("R9 irq off", 32'(irq), 0);
    done_pulse();
    #1 check("R9 irq tc", 32'(irq), 1);
    wr(5'h18, 32'h80);
    #1 check("R9 irq cleared", 32'(irq), 0);
    wr(5'h10, 32'h01);
    #1 check("R9 irq tx empty", 32'(irq), 1);
    wr(5'h10, 32'h04);
    #1 check("R9 irq tx not full", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_tx_order();
    t_tx_full();
    t_rx();
    t_rx_ovf();
    t_thresholds();
    t_tc_w1c();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule